// File: doc/BRIEF.md
# Pulsed Overload Protection Timer

This block decides when the supply output to an outdoor unit may be driven. It watches a digitised overcurrent comparator and two temperature comparators, and it drives the power stage enable, the enable of the bypass switch that hands supply duty to an upstream receiver, an overload flag and an over-temperature flag. The current clamp and the analog thresholds sit outside the block.

In dynamic mode, an overload turns the output off for a long cool-off window. A short retry window follows, one tenth the length of the cool-off window. If the fault shows up during the retry window, the cycle starts again. If the retry window runs clean, the block returns to normal operation. In static mode the output stays on, because the external clamp limits the current, and the overload flag simply tracks the fault. An over-temperature latch with two thresholds overrides everything else. Both windows are counted in prescaled ticks, so the same logic serves real time scales and short test runs.

Top module: `ovl_guard`

## Requirements
- R1: After a reset with `en_i` low, `pwr_en`=0, `bypass_en`=1, `ovl_flag`=0 and `hot_flag`=0.
- R2: Without over-temperature, `en_i`=0 gives `pwr_en`=0 and `bypass_en`=1, and `en_i`=1 with no fault gives `pwr_en`=1 and `bypass_en`=0, in the same cycle.
- R3: In dynamic mode (`static_sel`=0), `ovl_raw` passes through a two-stage synchroniser. It drops `pwr_en` and raises `ovl_flag` on the third rising edge after it is applied.
- R4: The cool-off window holds `pwr_en` low for exactly OFF_TICKS*PRESCALE cycles. A retry window of (OFF_TICKS/10)*PRESCALE cycles with `pwr_en`=1 and `ovl_flag`=1 then follows.
- R5: If the synchronised fault is seen in any cycle of the retry window, a new cool-off window starts at the end of the retry window.
- R6: A retry window with no fault returns the block to normal operation and clears `ovl_flag` at its end.
- R7: In static mode (`static_sel`=1), `pwr_en` stays 1 and `ovl_flag` equals `ovl_raw` delayed by two rising edges.
- R8: Setting `static_sel` during a running cycle returns the block to normal operation on the next clock edge. Dropping `static_sel` again with no fault leaves `pwr_en`=1 and `ovl_flag`=0.
- R9: `hot_i`=1 sets `hot_flag` on the next edge. While `hot_flag`=1, both `pwr_en` and `bypass_en` are 0, whatever the value of `en_i`.
- R10: `hot_flag` stays set while `hot_i` and `cool_i` are both 0. It clears on the edge after `cool_i`=1 is seen with `hot_i`=0.
- R11: Dropping `en_i` during a dynamic cycle abandons the cycle. `ovl_flag` clears on the next edge, and a later enable starts in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Power stage enable request |
| static_sel | input | 1 | 1 = static clamp mode, 0 = dynamic retry mode |
| ovl_raw | input | 1 | Asynchronous overcurrent comparator output |
| hot_i | input | 1 | Junction above upper temperature threshold |
| cool_i | input | 1 | Junction below lower temperature threshold |
| pwr_en | output | 1 | Enable for step-up and linear stages |
| bypass_en | output | 1 | Enable for the bypass switch |
| ovl_flag | output | 1 | Overload indication |
| hot_flag | output | 1 | Over-temperature indication |

## Verification
The enable outputs depend combinationally on `en_i` and `static_sel`, so their checks are due in the same cycle as the stimulus. The thermal flag is due one edge after its input, and an overload takes effect three edges after `ovl_raw` is applied. Window boundaries fall at fixed offsets from the fault edge: with PRESCALE=2 and OFF_TICKS=20, the output is off from cycle +3 through +42, back on at +43, and the retry decision lands at +47. The driver queues each expectation with its absolute due cycle, and the monitor compares it on the falling edge of exactly that cycle. The last cycle before each boundary is also checked.

// File: rtl/ovl_guard_pkg.sv
// Shared types for the overload protection timer.
package ovl_guard_pkg;
    // Protection sequencer states; RUN is normal operation.
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_COOLOFF = 2'd1,
        ST_RETRY   = 2'd2
    } guard_state_t;
endpackage

// File: rtl/ovl_sync2.sv
// Two-flop synchroniser for the asynchronous overcurrent comparator.
// Assumes the input is a level that is held for more than two clocks.
module ovl_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Two stages in series; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/therm_latch.sv
// Over-temperature flag with hysteresis. It sets when the upper comparator
// fires and clears only once the lower comparator reports cooling.
// Assumes both comparator inputs are already synchronous to clk.
module therm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic cool_i,
    output logic flag
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hot_i)  flag <= 1'b1;
        else if (cool_i) flag <= 1'b0;
    end
endmodule

// File: rtl/win_timer.sv
// Prescaled window timer. A start pulse clears it. done is high in the
// last cycle of a window of limit*PRESCALE cycles. The limit may change
// between windows but must stay fixed within one.
module win_timer #(
    parameter int PRESCALE = 1000,
    parameter int TICK_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TICK_W-1:0] limit,
    output logic              done
);
    localparam int PRE_W = $clog2(PRESCALE > 1 ? PRESCALE : 2);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0]  pre_cnt;
    logic [TICK_W-1:0] tick_cnt;

    // Prescaler followed by a tick counter; start restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else if (pre_cnt == PRE_LAST) begin
            pre_cnt  <= '0;
            tick_cnt <= tick_cnt + TICK_W'(1);
        end else begin
            pre_cnt  <= pre_cnt + PRE_W'(1);
        end
    end

    // Last cycle of the last tick.
    always_comb done = (pre_cnt == PRE_LAST) && (tick_cnt == limit - TICK_W'(1));
endmodule

// File: rtl/retry_fsm.sv
// Dynamic overload sequencer: RUN -> COOLOFF -> RETRY -> (COOLOFF | RUN).
// Whenever it is not armed (disabled, hot, or static mode) it returns
// to RUN on the next edge. Each window entry pulses win_start.
module retry_fsm
    import ovl_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic         ovl_s,
    input  logic         win_done,
    output guard_state_t state,
    output logic         win_start
);
    guard_state_t nxt;
    logic         seen;

    // Next-state and window-start decode.
    always_comb begin
        nxt       = state;
        win_start = 1'b0;
        if (!armed) begin
            nxt = ST_RUN;
        end else begin
            case (state)
                ST_RUN: if (ovl_s) begin
                    nxt       = ST_COOLOFF;
                    win_start = 1'b1;
                end
                ST_COOLOFF: if (win_done) begin
                    nxt       = ST_RETRY;
                    win_start = 1'b1;
                end
                ST_RETRY: if (win_done) begin
                    if (seen || ovl_s) begin
                        nxt       = ST_COOLOFF;
                        win_start = 1'b1;
                    end else begin
                        nxt = ST_RUN;
                    end
                end
                default: nxt = ST_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Sticky record of a fault observed during the retry window.
    always_ff @(posedge clk) begin
        if (!rst_n || win_start)  seen <= 1'b0;
        else if (state == ST_RETRY) seen <= seen | ovl_s;
    end
endmodule

// File: rtl/ovl_guard.sv
// Top level of the overload protection timer. It combines the overcurrent
// synchroniser, the thermal latch, the window timer and the retry
// sequencer into the output enables and flags. Assumes OFF_TICKS >= 10 so
// that the retry window is at least one tick long.
module ovl_guard
    import ovl_guard_pkg::*;
#(
    parameter int PRESCALE  = 1000,
    parameter int OFF_TICKS = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic static_sel,
    input  logic ovl_raw,
    input  logic hot_i,
    input  logic cool_i,
    output logic pwr_en,
    output logic bypass_en,
    output logic ovl_flag,
    output logic hot_flag
);
    localparam int ON_TICKS = OFF_TICKS / 10;
    localparam int TICK_W   = $clog2(OFF_TICKS + 1);

    logic              ovl_s;
    logic              armed;
    logic              win_start;
    logic              win_done;
    logic [TICK_W-1:0] tick_limit;
    guard_state_t      state;

    ovl_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ovl_raw),
        .q     (ovl_s)
    );

    therm_latch u_therm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_i  (hot_i),
        .cool_i (cool_i),
        .flag   (hot_flag)
    );

    // The sequencer runs only in dynamic mode with the output requested and cool.
    always_comb armed = en_i && !hot_flag && !static_sel;

    // Window length follows the window being timed.
    always_comb tick_limit = (state == ST_RETRY) ? TICK_W'(ON_TICKS) : TICK_W'(OFF_TICKS);

    win_timer #(
        .PRESCALE (PRESCALE),
        .TICK_W   (TICK_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (win_start),
        .limit (tick_limit),
        .done  (win_done)
    );

    retry_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .ovl_s     (ovl_s),
        .win_done  (win_done),
        .state     (state),
        .win_start (win_start)
    );

    // Output enables: heat opens everything; cool-off blocks only the power stage.
    always_comb begin
        pwr_en    = en_i && !hot_flag && (static_sel || state != ST_COOLOFF);
        bypass_en = !en_i && !hot_flag;
    end

    // Overload flag: tracks the fault in static mode, the cycle in dynamic mode.
    always_comb ovl_flag = static_sel ? ovl_s : (state != ST_RUN);
endmodule

// File: rtl/ovl_guard_chk.sv
// Port-level property checker for ovl_guard, attached by bind.
module ovl_guard_chk #(
    parameter int OFF_CYC = 900000
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic static_sel,
    input logic hot_i,
    input logic cool_i,
    input logic pwr_en,
    input logic bypass_en,
    input logic ovl_flag,
    input logic hot_flag
);
    logic [31:0] off_cnt;

    // Length of the current dynamic-mode outage, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || static_sel || !en_i || hot_flag || pwr_en) off_cnt <= '0;
        else                                                     off_cnt <= off_cnt + 32'd1;
    end

    // R9
    hot_cuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot_flag |-> (!pwr_en && !bypass_en));

    // R2
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !hot_flag) |-> (bypass_en && !pwr_en));

    // R10
    hot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hot_flag) |-> $past(hot_i));

    // R10
    hot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hot_flag) |-> ($past(cool_i) && !$past(hot_i)));

    // R7
    static_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (static_sel && en_i && !hot_flag) |-> pwr_en);

    // R3
    dyn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_sel && en_i && !hot_flag && !pwr_en) |-> ovl_flag);

    // R4
    off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_cnt <= 32'(OFF_CYC));
endmodule

bind ovl_guard ovl_guard_chk #(.OFF_CYC(PRESCALE * OFF_TICKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .static_sel (static_sel),
    .hot_i      (hot_i),
    .cool_i     (cool_i),
    .pwr_en     (pwr_en),
    .bypass_en  (bypass_en),
    .ovl_flag   (ovl_flag),
    .hot_flag   (hot_flag)
);

// File: tb/ovl_guard_test.sv
// Scoreboard bench: the driver queues expected outputs with due cycles,
// and the monitor compares them on the falling edge of that cycle.
module ovl_guard_test;
    localparam int PS = 2;
    localparam int OT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, static_sel = 1'b0, ovl_raw = 1'b0, hot_i = 1'b0, cool_i = 1'b0;
    logic pwr_en, bypass_en, ovl_flag, hot_flag;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        logic  p, b, o, t;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    ovl_guard #(.PRESCALE(PS), .OFF_TICKS(OT)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .static_sel(static_sel),
        .ovl_raw(ovl_raw), .hot_i(hot_i), .cool_i(cool_i),
        .pwr_en(pwr_en), .bypass_en(bypass_en), .ovl_flag(ovl_flag), .hot_flag(hot_flag)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int due, input logic p, input logic b,
                             input logic o, input logic t, input string tag);
        exp_t e;
        e.due = due; e.p = p; e.b = b; e.o = o; e.t = t; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compare every queued expectation in its due cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (e.due != cyc || pwr_en !== e.p || bypass_en !== e.b ||
                ovl_flag !== e.o || hot_flag !== e.t) begin
                errors++;
                $display("FAIL %s cycle %0d: pwr=%b byp=%b olf=%b otf=%b expected %b %b %b %b (due %0d)",
                         e.tag, cyc, pwr_en, bypass_en, ovl_flag, hot_flag,
                         e.p, e.b, e.o, e.t, e.due);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        int k;
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(cyc, 0, 1, 0, 0, "R1 reset");
        step(2);

        // R2 enable
        en_i = 1'b1;
        expect_at(cyc, 1, 0, 0, 0, "R2 enable");
        step(2);
        en_i = 1'b0;
        expect_at(cyc, 0, 1, 0, 0, "R2 disable");
        step(2);
        en_i = 1'b1;
        step(2);

        // R3 R4 R6: single fault, clean retry
        k = cyc;
        ovl_raw = 1'b1;
        expect_at(k + 2, 1, 0, 0, 0, "R3 before sync");
        expect_at(k + 3, 0, 0, 1, 0, "R3 cut off");
        step(10);
        ovl_raw = 1'b0;
        expect_at(k + 42, 0, 0, 1, 0, "R4 last off cycle");
        expect_at(k + 43, 1, 0, 1, 0, "R4 retry on");
        expect_at(k + 46, 1, 0, 1, 0, "R4 retry end");
        expect_at(k + 47, 1, 0, 0, 0, "R6 normal");
        step(k + 50 - cyc);

        // R5: fault persists through retry
        k = cyc;
        ovl_raw = 1'b1;
        expect_at(k + 3, 0, 0, 1, 0, "R5 first off");
        expect_at(k + 43, 1, 0, 1, 0, "R5 retry");
        expect_at(k + 47, 0, 0, 1, 0, "R5 second off");
        step(60);
        ovl_raw = 1'b0;
        expect_at(k + 86, 0, 0, 1, 0, "R5 second off end");
        expect_at(k + 87, 1, 0, 1, 0, "R5 second retry");
        expect_at(k + 91, 1, 0, 0, 0, "R6 recovered");
        step(k + 95 - cyc);

        // R7 static mode
        static_sel = 1'b1;
        step(2);
        k = cyc;
        ovl_raw = 1'b1;
        expect_at(k + 1, 1, 0, 0, 0, "R7 flag delayed");
        expect_at(k + 2, 1, 0, 1, 0, "R7 flag up");
        step(5);
        ovl_raw = 1'b0;
        expect_at(k + 6, 1, 0, 1, 0, "R7 flag held");
        expect_at(k + 7, 1, 0, 0, 0, "R7 flag down");
        step(5);

        // R8 mode switch mid-cycle
        static_sel = 1'b0;
        step(2);
        k = cyc;
        ovl_raw = 1'b1;
        expect_at(k + 3, 0, 0, 1, 0, "R8 cycle running");
        step(10);
        ovl_raw = 1'b0;
        step(5);
        static_sel = 1'b1;
        step(1);
        static_sel = 1'b0;
        expect_at(cyc, 1, 0, 0, 0, "R8 back to normal");
        expect_at(cyc + 4, 1, 0, 0, 0, "R8 stays normal");
        step(10);

        // R11 enable drop abandons the cycle
        k = cyc;
        ovl_raw = 1'b1;
        expect_at(k + 3, 0, 0, 1, 0, "R11 cycle running");
        step(10);
        ovl_raw = 1'b0;
        en_i = 1'b0;
        expect_at(cyc, 0, 1, 1, 0, "R11 disabled");
        expect_at(cyc + 1, 0, 1, 0, 0, "R11 flag cleared");
        step(3);
        en_i = 1'b1;
        expect_at(cyc, 1, 0, 0, 0, "R11 re-enable normal");
        step(3);

        // R9 R10 over-temperature
        k = cyc;
        hot_i = 1'b1;
        expect_at(k, 1, 0, 0, 0, "R9 before latch");
        expect_at(k + 1, 0, 0, 0, 1, "R9 hot cut");
        step(3);
        en_i = 1'b0;
        expect_at(cyc, 0, 0, 0, 1, "R9 bypass open");
        step(2);
        hot_i = 1'b0;
        expect_at(cyc + 3, 0, 0, 0, 1, "R10 hysteresis hold");
        step(5);
        cool_i = 1'b1;
        expect_at(cyc, 0, 0, 0, 1, "R10 before clear");
        expect_at(cyc + 1, 0, 1, 0, 0, "R10 cleared");
        step(3);
        cool_i = 1'b0;
        en_i = 1'b1;
        expect_at(cyc, 1, 0, 0, 0, "R10 resumed");
        step(3);

        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations unchecked, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule